// File: doc/BRIEF.md
# Multicycle Core with Inline Literal Load

A small 32-bit multicycle processor. One shared memory port serves both instruction fetch and data access. A state machine steps every instruction through fetch, a memory wait cycle, decode and a short execute or write-back phase. The core handles four base operations: add-immediate, load word, store word and branch-if-equal. It also has a two-word literal-load operation. The second word of that operation is a raw 32-bit value, and the core writes it straight into a register.

The literal word is obtained without an extra fetch. Fetch has already moved the PC past the instruction word. The decode cycle then issues a memory read at that PC, and the literal arrives during the following cycle. In the same decode cycle the branch-target register is loaded with PC plus the scaled immediate. The literal-load form always carries an immediate of 1, so the branch target points past the literal. The final step writes the register and reloads the PC from the branch target. A parameter selects the other sequence, in which the final step advances the PC by four instead. Both sequences land on the word after the literal.

The memory sits outside the core and returns read data one clock after the request. Every read is therefore followed by a wait cycle before its data is used. A retire pulse and a register observation port let an environment follow the progress of a program.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high, `pc_o` equals RESET_PC (0 by default), `retire_o` is 0 and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: Fetch requests a read at the PC in its first cycle. The PC holds for the following wait cycle and then advances by 4, with the returned word captured as the instruction.
- R3: Add-immediate (opcode 0x08) writes rs + sign-extended imm into rt. The instruction layout is op in bits 31:26, rs in bits 25:21, rt in bits 20:16 and imm in bits 15:0.
- R4: Load word (opcode 0x23) writes the memory word at rs + sign-extended imm into rt. This holds for positive and negative offsets.
- R5: Store word (opcode 0x2B) writes rt to address rs + sign-extended imm. The write strobe lasts exactly one cycle and is never active together with a read.
- R6: Branch-if-equal (opcode 0x04) sets the PC to α+4+sext(imm)×4 when rs equals rt, and to α+4 otherwise. Instructions that are branched over do not execute.
- R7: Literal load (opcode 0x3E, imm = 1) at address α writes the word stored at α+4 into rt and leaves the PC at α+8. The decode cycle issues the read at α+4, and the literal word is never executed.
- R8: Register 0 reads as zero. Writes to it, including a literal load that targets it, have no effect.
- R9: An unrecognised opcode returns to fetch with PC = α+4 and writes no register and no memory word.
- R10: `retire_o` is a one-cycle pulse at the end of each instruction. It coincides with the final PC, which is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the memory request |
| mem_rd_en | output | 1 | Read request; data is expected on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data from memory |
| pc_o | output | 32 | Current program counter |
| retire_o | output | 1 | One-cycle pulse when an instruction completes |
| obs_sel | input | 5 | Register index to observe |
| obs_data | output | 32 | Registered contents of register `obs_sel`, one cycle later |

## Verification
A single program interleaves literal loads with the base operations. Each literal load is immediately followed by an instruction that consumes the literal, which separates a correctly fetched literal from one that was executed as an instruction or read from the wrong address. Add-immediate and load word are tried with both positive and negative offsets, which exposes sign-extension faults. Branches are tried both taken and not taken, with trap instructions placed in the skipped slots. Literal loads and add-immediates that target register 0, together with an unrecognised opcode whose rt field names a live register, show whether writes leak through.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int RF_AW   = 5;
  localparam int IMM_W   = 16;
  localparam int NREGS   = 1 << RF_AW;

  localparam logic [OP_W-1:0] OP_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OP_LW   = 6'h23;
  localparam logic [OP_W-1:0] OP_SW   = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OP_LDC  = 6'h3E;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_DECODE,
    ST_ADDI,
    ST_LWADDR,
    ST_LWWB,
    ST_SW,
    ST_BEQ,
    ST_LDC
  } state_t;

  typedef enum logic [1:0] {
    PCS_INC,
    PCS_BR,
    PCS_LDC
  } pc_src_t;

  typedef struct packed {
    logic    ir_we;
    logic    pc_we;
    pc_src_t pc_src;
    logic    bpc_we;
    logic    rf_we;
    logic    wb_from_mem;
    logic    mem_rd;
    logic    mem_wr;
    logic    addr_from_alu;
  } ctrl_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_ADDI) || (op == OP_LW) || (op == OP_SW) ||
           (op == OP_BEQ)  || (op == OP_LDC);
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic [AW-1:0]   ra_c,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_c
);

  logic [XLEN-1:0] regs [NREGS];

  // index 0 is never written; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd_a <= (ra_a == '0) ? '0 : regs[ra_a];
    rd_b <= (ra_b == '0) ? '0 : regs[ra_b];
    rd_c <= (ra_c == '0) ? '0 : regs[ra_c];
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  sum,
  output logic [XLEN-1:0]  br_tgt,
  output logic             eq
);

  logic [XLEN-1:0] sext;

  always_comb begin
    sext   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    sum    = opa + sext;
    br_tgt = pc + {sext[XLEN-3:0], 2'b00};
    eq     = (opa == opb);
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            operands_eq,
  output state_t          state_o,
  output ctrl_t           ctrl_o,
  output logic            retire_o
);

  state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctrl_o  = '0;
    unique case (state_q)
      ST_FETCH: begin
        ctrl_o.mem_rd = !rst;
        state_d       = ST_FWAIT;
      end
      ST_FWAIT: begin
        ctrl_o.ir_we  = 1'b1;
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_src = PCS_INC;
        state_d       = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.bpc_we = 1'b1;
        // early pull of the word that follows the instruction
        ctrl_o.mem_rd = (opcode == OP_LDC);
        unique case (opcode)
          OP_ADDI: state_d = ST_ADDI;
          OP_LW:   state_d = ST_LWADDR;
          OP_SW:   state_d = ST_SW;
          OP_BEQ:  state_d = ST_BEQ;
          OP_LDC:  state_d = ST_LDC;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_ADDI: begin
        ctrl_o.rf_we = 1'b1;
        state_d      = ST_FETCH;
      end
      ST_LWADDR: begin
        ctrl_o.mem_rd        = 1'b1;
        ctrl_o.addr_from_alu = 1'b1;
        state_d              = ST_LWWB;
      end
      ST_LWWB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
        state_d            = ST_FETCH;
      end
      ST_SW: begin
        ctrl_o.mem_wr        = 1'b1;
        ctrl_o.addr_from_alu = 1'b1;
        state_d              = ST_FETCH;
      end
      ST_BEQ: begin
        ctrl_o.pc_we  = operands_eq;
        ctrl_o.pc_src = PCS_BR;
        state_d       = ST_FETCH;
      end
      ST_LDC: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
        ctrl_o.pc_we       = 1'b1;
        ctrl_o.pc_src      = PCS_LDC;
        state_d            = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      retire_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      retire_o <= (state_d == ST_FETCH) && (state_q != ST_FETCH);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int               XLEN            = 32,
  parameter logic [XLEN-1:0]  RESET_PC        = '0,
  parameter bit               LDC_PC_FROM_BPC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  mem_addr,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  pc_o,
  output logic             retire_o,
  input  logic [RF_AW-1:0] obs_sel,
  output logic [XLEN-1:0]  obs_data
);

  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  state_t              st;
  ctrl_t               ctl;
  logic [INSTR_W-1:0]  ir_q;
  logic [XLEN-1:0]     pc_q, bpc_q;
  logic [XLEN-1:0]     rs_val, rt_val;
  logic [XLEN-1:0]     alu_sum, br_tgt, ldc_next_pc, pc_d, wb_data;
  logic                eq;

  logic [OP_W-1:0]     f_op;
  logic [RF_AW-1:0]    f_rs, f_rt;
  logic [IMM_W-1:0]    f_imm;

  assign f_op  = ir_q[INSTR_W-1 -: OP_W];
  assign f_rs  = ir_q[INSTR_W-OP_W-1 -: RF_AW];
  assign f_rt  = ir_q[INSTR_W-OP_W-RF_AW-1 -: RF_AW];
  assign f_imm = ir_q[IMM_W-1:0];

  mc_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .opcode      (f_op),
    .operands_eq (eq),
    .state_o     (st),
    .ctrl_o      (ctl),
    .retire_o    (retire_o)
  );

  mc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk  (clk),
    .we   (ctl.rf_we),
    .wa   (f_rt),
    .wd   (wb_data),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .ra_c (obs_sel),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .rd_c (obs_data)
  );

  mc_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
    .opa    (rs_val),
    .opb    (rt_val),
    .pc     (pc_q),
    .imm    (f_imm),
    .sum    (alu_sum),
    .br_tgt (br_tgt),
    .eq     (eq)
  );

  // two ways to step past the literal word
  generate
    if (LDC_PC_FROM_BPC) begin : g_ldc_bpc
      assign ldc_next_pc = bpc_q;
    end else begin : g_ldc_inc
      assign ldc_next_pc = pc_q + WORD_BYTES;
    end
  endgenerate

  always_comb begin
    unique case (ctl.pc_src)
      PCS_BR:  pc_d = bpc_q;
      PCS_LDC: pc_d = ldc_next_pc;
      default: pc_d = pc_q + WORD_BYTES;
    endcase
    wb_data = ctl.wb_from_mem ? mem_rdata : alu_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      bpc_q <= RESET_PC;
      ir_q  <= '0;
    end else begin
      if (ctl.pc_we)  pc_q  <= pc_d;
      if (ctl.bpc_we) bpc_q <= br_tgt;
      if (ctl.ir_we)  ir_q  <= mem_rdata[INSTR_W-1:0];
    end
  end

  assign mem_addr  = ctl.addr_from_alu ? alu_sum : pc_q;
  assign mem_rd_en = ctl.mem_rd;
  assign mem_wr_en = ctl.mem_wr;
  assign mem_wdata = rt_val;
  assign pc_o      = pc_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  pc,
  input logic             retire,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [XLEN-1:0]  mem_addr,
  input state_t           st,
  input logic [OP_W-1:0]  op,
  input logic [IMM_W-1:0] imm
);

  always @(posedge clk) begin
    if (rst) begin
      assert_rst_quiet_R1: assert (!mem_rd_en && !mem_wr_en && !retire);
    end
  end

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH) |-> (mem_rd_en && mem_addr == pc));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FWAIT) |=> (pc == $past(pc) + XLEN'(4)));

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);

  assert_ldc_early_read_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && op == OP_LDC) |-> (mem_rd_en && mem_addr == pc));

  assert_ldc_skip_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LDC && imm == 16'd1) |=> (pc == $past(pc) + XLEN'(4)));

  assert_unknown_op_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && !op_known(op)) |=> (st == ST_FETCH && !mem_wr_en));

  assert_retire_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);

  assert_pc_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pc        (pc_q),
  .retire    (retire_o),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr),
  .st        (st),
  .op        (ir_q[31:26]),
  .imm       (ir_q[15:0])
);

// File: tb/tb_mc_core.sv
module tb_mc_core;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_o, obs_data;
  logic        mem_rd_en, mem_wr_en, retire_o;
  logic [4:0]  obs_sel = '0;

  logic [31:0] mem [MEM_WORDS];
  int n_chk = 0, n_fail = 0, wr_cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .retire_o(retire_o), .obs_sel(obs_sel), .obs_data(obs_data)
  );

  // synchronous memory: data returns one clock after the request
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr_en) wr_cycles <= wr_cycles + 1;
  end

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_retire(input string req);
    int guard = 0;
    @(negedge clk);
    while (!retire_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (!retire_o) chk({req, " retire timeout"}, 32'h0, 32'h1);
  endtask

  task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
    obs_sel = idx;
    @(negedge clk);
    val = obs_data;
  endtask

  task automatic step(input string req, input logic [31:0] exp_pc,
                      input logic [4:0] r, input logic [31:0] exp_val);
    logic [31:0] v;
    wait_retire(req);
    chk({req, " pc"}, pc_o, exp_pc);
    read_reg(r, v);
    chk({req, " reg"}, v, exp_val);
  endtask

  task automatic load_program();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    mem[8'h00] = enc(6'h3E, 5'd0, 5'd1, 16'd1);   // literal -> r1
    mem[8'h01] = 32'hDEADBEEF;
    mem[8'h02] = enc(6'h08, 5'd0, 5'd2, 16'd5);
    mem[8'h03] = enc(6'h08, 5'd2, 5'd3, 16'hFFFD);
    mem[8'h04] = enc(6'h2B, 5'd0, 5'd1, 16'h0080);
    mem[8'h05] = enc(6'h23, 5'd0, 5'd4, 16'h0080);
    mem[8'h06] = enc(6'h08, 5'd0, 5'd8, 16'h0090);
    mem[8'h07] = enc(6'h23, 5'd8, 5'd9, 16'hFFF0);
    mem[8'h08] = enc(6'h3E, 5'd0, 5'd0, 16'd1);   // literal -> r0
    mem[8'h09] = 32'h12345678;
    mem[8'h0A] = enc(6'h08, 5'd2, 5'd0, 16'd7);
    mem[8'h0B] = enc(6'h04, 5'd2, 5'd3, 16'd4);
    mem[8'h0C] = enc(6'h3F, 5'd0, 5'd2, 16'd9);   // unknown opcode
    mem[8'h0D] = enc(6'h3E, 5'd0, 5'd5, 16'd1);
    mem[8'h0E] = 32'h80000001;
    mem[8'h0F] = enc(6'h08, 5'd5, 5'd6, 16'd1);
    mem[8'h10] = enc(6'h04, 5'd1, 5'd4, 16'd2);
    mem[8'h11] = enc(6'h08, 5'd0, 5'd2, 16'd99);
    mem[8'h12] = enc(6'h08, 5'd0, 5'd2, 16'd99);
    mem[8'h13] = enc(6'h3E, 5'd0, 5'd7, 16'd1);
    mem[8'h14] = 32'h0000FFFF;
    mem[8'h15] = enc(6'h04, 5'd0, 5'd0, 16'hFFFF);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc_o, 32'h0);
    chk("R1 quiet in reset", {29'h0, retire_o, mem_rd_en, mem_wr_en}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R2 fetch request", {31'h0, mem_rd_en}, 32'h1);
    chk("R2 fetch addr", mem_addr, 32'h0);
    @(negedge clk);
    chk("R2 pc holds in wait", pc_o, 32'h0);
    @(negedge clk);
    chk("R2 pc advanced", pc_o, 32'h4);
    chk("R7 decode read", {31'h0, mem_rd_en}, 32'h1);
    chk("R7 decode addr", mem_addr, 32'h4);
  endtask

  task automatic t_literal_basic();
    step("R7 literal r1", 32'h08, 5'd1, 32'hDEADBEEF);
  endtask

  task automatic t_addi();
    step("R3 addi pos", 32'h0C, 5'd2, 32'd5);
    step("R3 addi neg", 32'h10, 5'd3, 32'd2);
  endtask

  task automatic t_store_load();
    int w0;
    w0 = wr_cycles;
    wait_retire("R5 sw");
    chk("R5 sw pc", pc_o, 32'h14);
    chk("R5 sw data", mem[32], 32'hDEADBEEF);
    chk("R5 single strobe", 32'(wr_cycles - w0), 32'd1);
    step("R4 lw pos", 32'h18, 5'd4, 32'hDEADBEEF);
    step("R3 addi base", 32'h1C, 5'd8, 32'h90);
    step("R4 lw neg", 32'h20, 5'd9, 32'hDEADBEEF);
  endtask

  task automatic t_zero_reg();
    step("R8 literal r0", 32'h28, 5'd0, 32'h0);
    step("R8 addi r0", 32'h2C, 5'd0, 32'h0);
  endtask

  task automatic t_branch_not_taken();
    step("R6 beq not taken", 32'h30, 5'd3, 32'd2);
  endtask

  task automatic t_unknown();
    int w0;
    w0 = wr_cycles;
    step("R9 unknown op", 32'h34, 5'd2, 32'd5);
    chk("R9 no mem write", 32'(wr_cycles - w0), 32'd0);
  endtask

  task automatic t_literal_use();
    step("R7 literal r5", 32'h3C, 5'd5, 32'h80000001);
    step("R7 literal consumed", 32'h40, 5'd6, 32'h80000002);
  endtask

  task automatic t_branch_taken();
    step("R6 beq taken", 32'h4C, 5'd2, 32'd5);
    step("R7 literal after branch", 32'h54, 5'd7, 32'h0000FFFF);
    step("R6 beq backward", 32'h54, 5'd7, 32'h0000FFFF);
    wait_retire("R10 pulse");
    @(negedge clk);
    chk("R10 pulse width", {31'h0, retire_o}, 32'h0);
  endtask

  initial begin
    load_program();
    t_reset();
    t_literal_basic();
    t_addi();
    t_store_load();
    t_zero_reg();
    t_branch_not_taken();
    t_unknown();
    t_literal_use();
    t_branch_taken();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 32'h0, 32'h1);
      finish_run();
    end
  end

endmodule